// File: doc/BRIEF.md
# Radix-2 Recoded Add/Subtract Array Multiplier

A purely combinational signed multiplier built as a stack of rows. Each row is a chain of controlled add/subtract/transfer cells. A small per-row control block inspects one multiplier bit together with the bit just below it, called the reference bit. From that pair it tells every cell in the row to do one of three things with the aligned multiplicand: add it, subtract it, or leave the accumulated value untouched.

The top row serves the most significant multiplier bit. Each following row takes the previous row's result shifted up by one place, with a fresh least significant cell whose incoming partial bit is zero. Because of this the accumulator gains one bit per row. The multiplicand is widened by copying its sign bit so that it always matches the row width. The last row delivers the full-width two's complement product directly, with no correction step for negative operands.

The operand width is a parameter with a default of 4 bits. The product is twice that width.

Top module: `booth_cass_mult`

## Requirements
- R1: For every pair of N-bit two's complement operands, prod_o equals their signed product as a 2N-bit two's complement value (defaults: 4-bit operands, 8-bit product).
- R2: A row whose (multiplier bit, reference bit) pair is 00 or 11 passes its input through. A multiplier of 0 therefore gives a product of 0 for any multiplicand.
- R3: A pair of 01 adds the multiplicand and a pair of 10 subtracts it. The reference bit below bit 0 is 0. So a multiplier of 1 gives the sign-extended multiplicand, and a multiplier of all ones (-1) gives its negation.
- R4: Rows are ordered from the multiplier's MSB down, and each later row shifts the accumulated value left by one. A multiplier of 1000 (-8) gives the multiplicand times -8, which is the negated multiplicand shifted up by three places.
- R5: The multiplicand is sign-extended as rows widen, so the most negative multiplicand is handled exactly. For example, -8 x -8 gives 0x40 and 7 x -8 gives 0xC8.
- R6: Negative times negative yields the correct positive product without any final correction. For example, -1 x -1 gives 0x01 and -6 x -3 gives 0x12.
- R7: A multiplicand of 0 gives a product of 0 for any multiplier.
- R8: A multiplier with alternating bits, where every row adds or subtracts, still gives the exact product. For example, 3 x 0101 gives 0x0F and -4 x 1010 gives 0x18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Multiplicand, two's complement |
| mplr_i | input | N | Multiplier, two's complement |
| prod_o | output | 2N | Product, two's complement |

## Verification
The assertions compare the product against a signed reference on every input change. They also check the zero results for a zero multiplicand or multiplier, the product sign for nonzero operands, and the negation produced by an all-ones multiplier. Only the bench's scenarios show that the row order and the shift per row are right. It does this through chosen multipliers such as 1000 and the alternating patterns. It also walks all operand pairs at the default width to tie every recoded combination to an exact value.

// File: rtl/booth_cass_pkg.sv
package booth_cass_pkg;

  typedef enum logic [1:0] {
    ROW_PASS = 2'd0,
    ROW_ADD  = 2'd1,
    ROW_SUB  = 2'd2
  } row_op_e;

  // radix-2 recoding of (bit, reference bit)
  function automatic row_op_e recode(input logic bit_cur, input logic bit_ref);
    row_op_e op;
    unique case ({bit_cur, bit_ref})
      2'b01:   op = ROW_ADD;
      2'b10:   op = ROW_SUB;
      default: op = ROW_PASS;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_row_ctrl.sv
module booth_row_ctrl
  import booth_cass_pkg::*;
(
  input  logic bit_cur_i,
  input  logic bit_ref_i,
  output logic h_o,
  output logic d_o
);

  row_op_e op;

  always_comb begin
    op  = recode(bit_cur_i, bit_ref_i);
    h_o = (op != ROW_PASS);
    d_o = (op == ROW_SUB);
  end

endmodule

// File: rtl/cass_cell.sv
module cass_cell (
  input  logic pin_i,
  input  logic a_i,
  input  logic cin_i,
  input  logic h_i,
  input  logic d_i,
  output logic pout_o,
  output logic cout_o
);

  logic pin_eff;

  // d flips pin so one majority gate serves as carry or borrow
  assign pin_eff = pin_i ^ d_i;
  assign pout_o  = pin_i ^ (a_i & h_i) ^ (cin_i & h_i);
  assign cout_o  = h_i & ((pin_eff & a_i) | (pin_eff & cin_i) | (a_i & cin_i));

endmodule

// File: rtl/cass_row.sv
module cass_row #(
  parameter int W = 5
) (
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] a_i,
  input  logic         h_i,
  input  logic         d_i,
  output logic [W-1:0] pout_o
);

  logic [W:0] chain;
  logic       unused_top_carry;

  assign chain[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_cell
    cass_cell u_cell (
      .pin_i (pin_i[j]),
      .a_i   (a_i[j]),
      .cin_i (chain[j]),
      .h_i   (h_i),
      .d_i   (d_i),
      .pout_o(pout_o[j]),
      .cout_o(chain[j+1])
    );
  end

  // result fits W bits; carry/borrow out of the top is dropped
  assign unused_top_carry = chain[W];

endmodule

// File: rtl/booth_cass_mult.sv
module booth_cass_mult #(
  parameter int N = 4
) (
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplr_i,
  output logic [2*N-1:0] prod_o
);

  localparam int PW = 2 * N;

  logic [N:0]    mplr_ext;
  logic [PW-1:0] row_acc [N];

  assign mplr_ext = {mplr_i, 1'b0};

  for (genvar k = 0; k < N; k++) begin : g_row
    localparam int W  = N + 1 + k;
    localparam int BI = N - 1 - k;

    logic [W-1:0] pin, a_ext, pout;
    logic         h, d;

    booth_row_ctrl u_ctrl (
      .bit_cur_i(mplr_ext[BI+1]),
      .bit_ref_i(mplr_ext[BI]),
      .h_o      (h),
      .d_o      (d)
    );

    if (k == 0) begin : g_first
      assign pin = '0;
    end else begin : g_next
      assign pin = {row_acc[k-1][W-2:0], 1'b0};
    end

    assign a_ext = {{(W-N){mcand_i[N-1]}}, mcand_i};

    cass_row #(.W(W)) u_row (
      .pin_i (pin),
      .a_i   (a_ext),
      .h_i   (h),
      .d_i   (d),
      .pout_o(pout)
    );

    assign row_acc[k] = PW'($signed(pout));
  end

  assign prod_o = row_acc[N-1];

endmodule

// File: rtl/booth_cass_mult_chk.sv
module booth_cass_mult_chk #(
  parameter int N = 4
) (
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplr_i,
  input logic [2*N-1:0] prod_o
);

  localparam int PW = 2 * N;

  logic signed [PW-1:0] ref_p, neg_a;

  always_comb begin
    ref_p = PW'($signed(mcand_i)) * PW'($signed(mplr_i));
    neg_a = -PW'($signed(mcand_i));
    AST_PRODUCT_EXACT: assert ($signed(prod_o) == ref_p); // R1
    AST_ZERO_MPLR: assert (mplr_i != '0 || prod_o == '0); // R2
    AST_MINUS_ONE_NEGATES: assert (mplr_i != '1 || $signed(prod_o) == neg_a); // R3
    AST_ZERO_MCAND: assert (mcand_i != '0 || prod_o == '0); // R7
    AST_SIGN_OK: assert (mcand_i == '0 || mplr_i == '0 ||
                         prod_o[PW-1] == (mcand_i[N-1] ^ mplr_i[N-1])); // R6
  end

endmodule

bind booth_cass_mult booth_cass_mult_chk #(.N(N)) u_chk (
  .mcand_i(mcand_i),
  .mplr_i (mplr_i),
  .prod_o (prod_o)
);

// File: tb/booth_cass_mult_tb_top.sv
module booth_cass_mult_tb_top;

  localparam int N  = 4;
  localparam int PW = 2 * N;
  localparam int NV = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]  a, b;
  logic [PW-1:0] p;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  booth_cass_mult #(.N(N)) dut_i (
    .mcand_i(a),
    .mplr_i (b),
    .prod_o (p)
  );

  // {req, a, b, expected}
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 4'h3, 4'h0, 8'h00},  // R2
    {4'd2, 4'hB, 4'h0, 8'h00},  // R2
    {4'd3, 4'h5, 4'h1, 8'h05},  // R3
    {4'd3, 4'hD, 4'h1, 8'hFD},  // R3
    {4'd3, 4'h6, 4'hF, 8'hFA},  // R3
    {4'd3, 4'h8, 4'hF, 8'h08},  // R3
    {4'd4, 4'h3, 4'h8, 8'hE8},  // R4
    {4'd4, 4'hE, 4'h8, 8'h10},  // R4
    {4'd5, 4'h8, 4'h8, 8'h40},  // R5
    {4'd5, 4'h7, 4'h8, 8'hC8},  // R5
    {4'd5, 4'h8, 4'h7, 8'hC8},  // R5
    {4'd1, 4'h7, 4'h7, 8'h31},  // R1
    {4'd6, 4'hF, 4'hF, 8'h01},  // R6
    {4'd6, 4'hA, 4'hD, 8'h12},  // R6
    {4'd7, 4'h0, 4'h5, 8'h00},  // R7
    {4'd7, 4'h0, 4'h8, 8'h00},  // R7
    {4'd8, 4'h3, 4'h5, 8'h0F},  // R8
    {4'd8, 4'hC, 4'hA, 8'h18}   // R8
  };

  task automatic apply_check(input logic [N-1:0] av, input logic [N-1:0] bv,
                             input logic [PW-1:0] exp_p, input int req);
    @(posedge clk);
    a = av;
    b = bv;
    @(negedge clk);
    checks++;
    if (p !== exp_p) begin
      errors++;
      $display("FAIL R%0d: a=%h b=%h actual=%h expected=%h", req, av, bv, p, exp_p);
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    // idle state, R7: zero operands give zero
    apply_check('0, '0, '0, 7);
    for (int i = 0; i < NV; i++) begin
      apply_check(VEC[i][15:12], VEC[i][11:8], VEC[i][7:0], int'(VEC[i][19:16]));
    end
    // R1: exhaustive against a signed reference
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        logic signed [PW-1:0] ea, eb;
        ea = PW'($signed(N'(i)));
        eb = PW'($signed(N'(j)));
        apply_check(N'(i), N'(j), ea * eb, 1);
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule